// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer with Byte Lanes

This block is the glue between a processor whose address and data travel on one shared set of pins and a memory system with separate address and data buses split into an even bank and an odd bank. During the address phase, the processor drives the low 16 address bits on the shared bus and the top 4 bits on dedicated pins. An address-latch-enable strobe marks this phase, and the block captures the address and the active-low high-byte enable. After the strobe drops, the shared pins are free to carry data, and the captured address stays on the memory address bus.

The captured high-byte enable and address bit 0 together select which banks take part. A read or write strobe then qualifies that selection. The data steering path passes each selected byte lane between the shared bus and the memory data bus, in the direction the active strobe gives. It drives zero on every lane that is not selected and raises an output enable only on the side that should drive.

Top module: `busdemux_top`

## Requirements
- R1: While `ale` is high, `addr_out` equals `{a_hi, ad_in}` in the same cycle. The latch is transparent.
- R2: While `ale` is low, `addr_out` and the latched byte-high enable keep the values sampled at the last rising clock edge at which `ale` was high, whatever `ad_in`, `a_hi` and `bhe_n` do.
- R3: With latched `bhe_n`=0 and latched address bit 0 = 0, an active strobe asserts both `sel_even` and `sel_odd`. This is a 16-bit word transfer.
- R4: With latched `bhe_n`=0 and latched bit 0 = 1, an active strobe asserts only `sel_odd`. This is a high byte at an odd address.
- R5: With latched `bhe_n`=1 and latched bit 0 = 0, an active strobe asserts only `sel_even`. This is a low byte at an even address.
- R6: With latched `bhe_n`=1 and latched bit 0 = 1, neither select is asserted.
- R7: A strobe is active only when exactly one of `rd_n`, `wr_n` is low. When both are high or both are low, both selects stay low and neither output enable rises.
- R8: During an active write, `mem_wdata[15:8]` equals `ad_in[15:8]` if `sel_odd` is high and is zero otherwise. `mem_wdata[7:0]` equals `ad_in[7:0]` if `sel_even` is high and is zero otherwise. `mem_wdata_oe` is high exactly when a write is active and at least one select is high.
- R9: During an active read, `ad_out` carries `mem_rdata` using the same per-lane rule as R8: odd lane on bits 15:8, even lane on bits 7:0, and zero on unselected lanes. `ad_oe` is high exactly when a read is active and at least one select is high.
- R10: After reset, and before any `ale` pulse, the latched address is zero and the latched `bhe_n` is 1. A read in that state therefore selects only the even bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 16 | Shared address/data bus from the processor |
| a_hi | input | 4 | Address bits 19:16 |
| ale | input | 1 | Address latch enable, active high |
| bhe_n | input | 1 | High-byte enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| mem_rdata | input | 16 | Read data from the memory banks |
| addr_out | output | 20 | Latched memory address |
| sel_even | output | 1 | Even (low byte) bank select |
| sel_odd | output | 1 | Odd (high byte) bank select |
| mem_wdata | output | 16 | Steered write data to memory |
| mem_wdata_oe | output | 1 | Enable for the memory-side write data drivers |
| ad_out | output | 16 | Steered read data back to the processor |
| ad_oe | output | 1 | Enable for the processor-side read data drivers |

## Verification
The hardest case is the hold behaviour. A lane decision must come from the byte code and bit 0 captured during the address phase, not from what the shared pins carry later. The stimulus therefore latches an address with `ale` high. It then drops `ale` and drives a data word whose bit 0 and a `bhe_n` value are the opposite of the latched ones. A design that decodes live pins would pick the wrong lanes. This is swept over every byte code, every strobe combination and several address patterns.

// File: rtl/busdemux_pkg.sv
package busdemux_pkg;
    parameter int ADDR_W = 20;
    parameter int DATA_W = 16;
    parameter int LANE_W = 8;
    localparam int LANES = DATA_W / LANE_W;
    localparam int HI_W  = ADDR_W - DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              bhe_n;
    } latch_t;
endpackage

// File: rtl/busdemux_addr_latch.sv
module busdemux_addr_latch
    import busdemux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_bhe_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bhe_n_o
);
    latch_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (ale) begin
            lat_d.addr  = bus_addr;
            lat_d.bhe_n = bus_bhe_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q.addr  <= '0;
            lat_q.bhe_n <= 1'b1;
        end else begin
            lat_q <= lat_d;
        end
    end

    // Transparent while enabled, holding otherwise.
    assign addr_o  = ale ? bus_addr  : lat_q.addr;
    assign bhe_n_o = ale ? bus_bhe_n : lat_q.bhe_n;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(!ale)) |-> ($stable(addr_o) && $stable(bhe_n_o)));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ale) && $past(rst_n)) |-> (addr_o == $past(bus_addr)));
endmodule

// File: rtl/busdemux_lane_decode.sv
module busdemux_lane_decode
    import busdemux_pkg::*;
(
    input  logic             a0,
    input  logic             bhe_n,
    input  logic             rd_n,
    input  logic             wr_n,
    output logic [LANES-1:0] lane_sel,
    output logic             rd_act,
    output logic             wr_act
);
    logic any_act;

    always_comb begin
        rd_act      = !rd_n && wr_n;
        wr_act      = !wr_n && rd_n;
        any_act     = rd_act || wr_act;
        lane_sel    = '0;
        lane_sel[0] = any_act && !a0;
        lane_sel[1] = any_act && !bhe_n;
    end
endmodule

// File: rtl/busdemux_data_steer.sv
module busdemux_data_steer
    import busdemux_pkg::*;
(
    input  logic [LANES-1:0]  lane_sel,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] to_mem,
    output logic              to_mem_oe,
    output logic [DATA_W-1:0] to_cpu,
    output logic              to_cpu_oe
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign to_mem[l*LANE_W +: LANE_W] =
            (wr_act && lane_sel[l]) ? cpu_data[l*LANE_W +: LANE_W] : '0;
        assign to_cpu[l*LANE_W +: LANE_W] =
            (rd_act && lane_sel[l]) ? mem_data[l*LANE_W +: LANE_W] : '0;
    end

    assign to_mem_oe = wr_act && (|lane_sel);
    assign to_cpu_oe = rd_act && (|lane_sel);
endmodule

// File: rtl/busdemux_top.sv
module busdemux_top
    import busdemux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [HI_W-1:0]   a_hi,
    input  logic              ale,
    input  logic              bhe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_out,
    output logic              sel_even,
    output logic              sel_odd,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);
    logic             lat_bhe_n;
    logic [LANES-1:0] lane_sel;
    logic             rd_act, wr_act;

    busdemux_addr_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .bus_addr  ({a_hi, ad_in}),
        .bus_bhe_n (bhe_n),
        .addr_o    (addr_out),
        .bhe_n_o   (lat_bhe_n)
    );

    busdemux_lane_decode u_dec (
        .a0       (addr_out[0]),
        .bhe_n    (lat_bhe_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .lane_sel (lane_sel),
        .rd_act   (rd_act),
        .wr_act   (wr_act)
    );

    busdemux_data_steer u_steer (
        .lane_sel  (lane_sel),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .cpu_data  (ad_in),
        .mem_data  (mem_rdata),
        .to_mem    (mem_wdata),
        .to_mem_oe (mem_wdata_oe),
        .to_cpu    (ad_out),
        .to_cpu_oe (ad_oe)
    );

    assign sel_even = lane_sel[0];
    assign sel_odd  = lane_sel[1];

    assert_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (addr_out == {a_hi, ad_in}));

    assert_idle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n == wr_n) |-> (!sel_even && !sel_odd && !ad_oe && !mem_wdata_oe));

    assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ad_oe, mem_wdata_oe}));

    assert_no_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_bhe_n && addr_out[0]) |-> (!sel_even && !sel_odd));

    assert_read_unselected_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |-> (ad_out == '0));
endmodule

// File: tb/busdemux_top_tb.sv
module busdemux_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ad_in = '0;
    logic [3:0]  a_hi = '0;
    logic        ale = 1'b0;
    logic        bhe_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] mem_rdata = '0;
    logic [19:0] addr_out;
    logic        sel_even, sel_odd;
    logic [15:0] mem_wdata, ad_out;
    logic        mem_wdata_oe, ad_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busdemux_top u_dut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
        .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .mem_rdata(mem_rdata),
        .addr_out(addr_out), .sel_even(sel_even), .sel_odd(sel_odd),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .ad_out(ad_out), .ad_oe(ad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [4];
        bases[0] = 16'h0000;
        bases[1] = 16'hFFFE;
        bases[2] = 16'h5A3C;
        bases[3] = 16'h81F6;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state, read before any latch pulse
        rd_n = 1'b0;
        mem_rdata = 16'hBEEF;
        #2;
        check("R10 addr", addr_out, 20'h0);
        check("R10 sel_even", sel_even, 1'b1);
        check("R10 sel_odd", sel_odd, 1'b0);
        check("R10 ad_out", ad_out, 16'h00EF);
        @(negedge clk);
        rd_n = 1'b1;

        for (int ai = 0; ai < 4; ai++) begin
            for (int b = 0; b < 2; b++) begin
                for (int z = 0; z < 2; z++) begin
                    for (int m = 0; m < 4; m++) begin
                        logic [15:0] lo, dat, rdat;
                        logic [3:0]  hi;
                        logic [19:0] exp_addr;
                        logic        rdv, wrv, e_ev, e_od;
                        logic [15:0] e_w, e_r;
                        lo = {bases[ai][15:1], z[0]};
                        hi = 4'(ai * 5 + b * 3 + m);
                        exp_addr = {hi, lo};
                        // address phase
                        @(negedge clk);
                        ale = 1'b1;
                        ad_in = lo;
                        a_hi = hi;
                        bhe_n = b[0];
                        #2;
                        check("R1 transparent", addr_out, exp_addr);
                        // data phase: pins now carry opposite bit 0 and byte code
                        @(negedge clk);
                        ale = 1'b0;
                        dat = 16'hA5C3 ^ {lo[7:0], lo[15:8]};
                        dat[0] = ~z[0];
                        ad_in = dat;
                        a_hi = ~hi;
                        bhe_n = ~b[0];
                        rdat = 16'h3C96 ^ lo;
                        mem_rdata = rdat;
                        rd_n = !(m == 1 || m == 3);
                        wr_n = !(m == 2 || m == 3);
                        #2;
                        rdv = (m == 1);
                        wrv = (m == 2);
                        e_ev = (rdv || wrv) && !z[0];
                        e_od = (rdv || wrv) && !b[0];
                        e_w = {(wrv && e_od) ? dat[15:8] : 8'h00,
                               (wrv && e_ev) ? dat[7:0]  : 8'h00};
                        e_r = {(rdv && e_od) ? rdat[15:8] : 8'h00,
                               (rdv && e_ev) ? rdat[7:0]  : 8'h00};
                        check("R2 hold", addr_out, exp_addr);
                        if (b == 0 && z == 0)
                            check("R3 word sel", {sel_odd, sel_even}, {e_od, e_ev});
                        else if (b == 0)
                            check("R4 odd sel", {sel_odd, sel_even}, {e_od, e_ev});
                        else if (z == 0)
                            check("R5 even sel", {sel_odd, sel_even}, {e_od, e_ev});
                        else
                            check("R6 none sel", {sel_odd, sel_even}, 2'b00);
                        if (m == 0 || m == 3)
                            check("R7 idle", {sel_odd, sel_even, ad_oe, mem_wdata_oe}, 4'h0);
                        check("R8 wdata", mem_wdata, e_w);
                        check("R8 wdata_oe", mem_wdata_oe, wrv && (e_ev || e_od));
                        check("R9 rdata", ad_out, e_r);
                        check("R9 ad_oe", ad_oe, rdv && (e_ev || e_od));
                        // one more cycle with pins moving, still held
                        @(negedge clk);
                        ad_in = ~dat;
                        #2;
                        check("R2 hold2", addr_out, exp_addr);
                        @(negedge clk);
                        rd_n = 1'b1;
                        wr_n = 1'b1;
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule